// File: doc/BRIEF.md
# Carrier Activity Snapshot Sampler

This block watches the carrier-sense lines of every port on a repeater: one attachment-unit port and a set of twisted-pair ports. Each port has a sticky latch that records any carrier activity, even a single clock of it. When an external strobe arrives, the block takes a snapshot of all ports. A port's snapshot bit is set if its carrier was seen at any point since the previous strobe. The latches then clear for the next period.

The snapshot leaves the block serially, one bit per clock, with a valid flag, so an external shift register can collect it. Driving the strobe once per 10 bit times (1 µs) gives carrier activity at that resolution, and no short event between strobes is lost. A small state machine runs the output. It has two states, `ST_IDLE` and `ST_SHIFT`, and three transitions:
- `IDLE→SHIFT` on a strobe.
- `SHIFT→SHIFT` either as the normal bit-by-bit advance or as a restart when a new strobe arrives.
- `SHIFT→IDLE` after the last bit.

Top module: `crs_sampler`

## Requirements
- R1: After reset, `ser_vld` and `ser_dat` are 0, and the first snapshot taken with no carrier activity reads all zero.
- R2: A carrier pulse lasting a single clock, between two strobes, sets that port's bit in the next snapshot.
- R3: Carrier that is active only in the clock where `strb` is sampled high is included in that same snapshot.
- R4: A strobe clears every latch. A port with no carrier since the previous strobe reads 0 in the next snapshot.
- R5: The snapshot is sent LSB first, one bit per clock. Bit 0 (`crs_in[0]`) is the attachment-unit port, and bit k is twisted-pair port k-1. The first bit appears in the clock after the strobe edge.
- R6: `ser_vld` stays high for exactly NPORT (9) consecutive clocks per snapshot and is low otherwise. `ser_dat` is 0 whenever `ser_vld` is 0.
- R7: A strobe that arrives during shifting abandons the remaining bits and restarts with a new snapshot from bit 0.
- R8: A carrier held active across several strobes is reported in every snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crs_in | input | NPORT (9) | Carrier sense per port, bit 0 is the attachment-unit port |
| strb | input | 1 | One-clock sample strobe |
| ser_dat | output | 1 | Serial snapshot bit |
| ser_vld | output | 1 | High while `ser_dat` carries a snapshot bit |

## Verification
The hardest case is a strobe that cuts into a snapshot still being shifted out, while a one-clock carrier pulse is in flight. The bench drives a pulse three clocks after a strobe and then strobes again mid-shift. The scoreboard throws away the unsent expected bits at that strobe and expects the new snapshot from bit 0. It also exercises carrier that is present only in the strobe clock, to confirm that activity at that edge is neither lost nor counted twice.

// File: rtl/crs_sampler_pkg.sv
package crs_sampler_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } shift_state_e;
endpackage

// File: rtl/crs_sticky.sv
// Per-port sticky activity latches, cleared by the sample strobe.
module crs_sticky #(
    parameter int NPORT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] crs_in,
    input  logic             strb,
    output logic [NPORT-1:0] sticky
);
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sticky[p] <= 1'b0;
            end else if (strb) begin
                sticky[p] <= 1'b0;
            end else if (crs_in[p]) begin
                sticky[p] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/crs_shifter.sv
// Loads a snapshot on strobe and shifts it out LSB first.
module crs_shifter
    import crs_sampler_pkg::*;
#(
    parameter int NPORT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strb,
    input  logic [NPORT-1:0] snap,
    output logic             ser_dat,
    output logic             ser_vld
);
    localparam int CW = $clog2(NPORT + 1);
    localparam logic [CW-1:0] LAST = CW'(NPORT - 1);

    shift_state_e    state_q, state_d;
    logic [NPORT-1:0] sreg_q;
    logic [CW-1:0]    cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (strb) state_d = ST_SHIFT;
            ST_SHIFT: if (strb) state_d = ST_SHIFT;
                      else if (cnt_q == LAST) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (strb) begin
            sreg_q <= snap;
            cnt_q  <= '0;
        end else if (state_q == ST_SHIFT) begin
            sreg_q <= sreg_q >> 1;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign ser_vld = (state_q == ST_SHIFT);
    assign ser_dat = ser_vld & sreg_q[0];
endmodule

// File: rtl/crs_sampler.sv
module crs_sampler #(
    parameter int NTP   = 8,
    parameter int NPORT = NTP + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] crs_in,
    input  logic             strb,
    output logic             ser_dat,
    output logic             ser_vld
);
    logic [NPORT-1:0] sticky;
    logic [NPORT-1:0] snap;

    crs_sticky #(.NPORT(NPORT)) u_sticky (
        .clk(clk), .rst_n(rst_n), .crs_in(crs_in), .strb(strb), .sticky(sticky)
    );

    // activity in the strobe clock itself belongs to this snapshot (R3)
    assign snap = sticky | crs_in;

    crs_shifter #(.NPORT(NPORT)) u_shift (
        .clk(clk), .rst_n(rst_n), .strb(strb), .snap(snap),
        .ser_dat(ser_dat), .ser_vld(ser_vld)
    );
endmodule

// File: rtl/crs_sampler_chk.sv
module crs_sampler_chk #(
    parameter int NPORT = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPORT-1:0] crs_in,
    input logic             strb,
    input logic [NPORT-1:0] sticky,
    input logic             ser_dat,
    input logic             ser_vld
);
    localparam int CW = $clog2(NPORT + 2);
    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n)       run <= '0;
        else if (strb)    run <= '0;
        else if (ser_vld) run <= run + 1'b1;
        else              run <= '0;
    end

    a_r2_pulse_latched: assert property (@(posedge clk) disable iff (!rst_n)
        !strb |=> ((sticky & $past(crs_in)) == $past(crs_in)));
    a_r4_strobe_clears: assert property (@(posedge clk) disable iff (!rst_n)
        strb |=> (sticky == '0));
    a_r7_strobe_starts: assert property (@(posedge clk) disable iff (!rst_n)
        strb |=> ser_vld);
    a_r6_dat_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_vld |-> !ser_dat);
    a_r6_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ser_vld |-> (run < CW'(NPORT)));
endmodule

bind crs_sampler crs_sampler_chk #(.NPORT(NPORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .crs_in(crs_in), .strb(strb),
    .sticky(sticky), .ser_dat(ser_dat), .ser_vld(ser_vld)
);

// File: tb/crs_sampler_tb.sv
module crs_sampler_tb;
    localparam int NPORT = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NPORT-1:0] crs_in = '0;
    logic             strb = 1'b0;
    logic             ser_dat, ser_vld;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [NPORT-1:0] act = '0;
    bit    q_bit[$];
    string q_tag[$];
    int    q_idx[$];

    always #2 clk = ~clk;

    crs_sampler #(.NTP(NPORT-1)) u_dut (
        .clk(clk), .rst_n(rst_n), .crs_in(crs_in), .strb(strb),
        .ser_dat(ser_dat), .ser_vld(ser_vld)
    );

    task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    // drive one clock of stimulus; model the expected snapshot
    task automatic step(input logic [NPORT-1:0] c, input bit s, input string tag);
        @(negedge clk);
        crs_in = c;
        strb   = s;
        if (s) begin
            logic [NPORT-1:0] e;
            e = act | c;
            act = '0;
            q_bit.delete(); q_tag.delete(); q_idx.delete();   // R7 restart
            for (int i = 0; i < NPORT; i++) begin
                q_bit.push_back(e[i]); q_tag.push_back(tag); q_idx.push_back(i);
            end
        end else begin
            act = act | c;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, 1'b0, "");
    endtask

    // monitor: samples 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (ser_vld) begin
                if (q_bit.size() == 0) begin
                    check(1'b0, "R6 extra valid bit", 1, 0);
                end else begin
                    bit b; string t; int k;
                    b = q_bit.pop_front(); t = q_tag.pop_front(); k = q_idx.pop_front();
                    check(ser_dat == b, $sformatf("%s bit%0d", t, k), ser_dat, b);
                end
            end else begin
                check(ser_dat == 1'b0, "R6 dat quiet", ser_dat, 0);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ser_vld == 1'b0, "R1 reset vld", ser_vld, 0);
        check(ser_dat == 1'b0, "R1 reset dat", ser_dat, 0);
        @(negedge clk) rst_n = 1'b1;
        idle(3);
        step('0, 1'b1, "R1 zero snapshot"); idle(12);
        step(9'h008, 1'b0, "");  idle(4);            // one-clock pulse on TP2
        step('0, 1'b1, "R2 single pulse"); idle(12);
        step(9'h101, 1'b0, ""); idle(2);            // AUI and last TP port
        step('0, 1'b1, "R5 order"); idle(12);
        step(9'h020, 1'b1, "R3 strobe-cycle carrier"); idle(12);
        step('0, 1'b1, "R4 cleared"); idle(12);
        for (int r = 0; r < 3; r++) begin              // R8 held carrier
            for (int i = 0; i < 5; i++) step(9'h004, 1'b0, "");
            step(9'h004, 1'b1, "R8 held");
            for (int i = 0; i < 11; i++) step(9'h004, 1'b0, "");
        end
        idle(2);
        step('0, 1'b1, "R7 first"); idle(2);
        step(9'h002, 1'b0, ""); 
        step(9'h040, 1'b1, "R7 restart"); idle(12);
        check(q_bit.size() == 0, "R6 all bits delivered", q_bit.size(), 0);
        check(ser_vld == 1'b0, "R6 idle at end", ser_vld, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule